// File: doc/BRIEF.md
# System-Management Interrupt Enable and Status Registers

This block holds the two 32-bit control words that govern system-management interrupts inside a power-management I/O window. The window is 8 bytes wide. The enable word sits at byte offset 0 and the status word sits at byte offset 4. Software reaches both words through a plain register port with separate read and write strobes and a byte offset. Reads are combinational. Writes take effect on the next rising clock edge.

Every write to the enable word passes through an internal write mask. The mask is loaded only at reset, with all ones by default. A parameter can change that reset value so that a test can narrow the mask. A separate timer-control block supplies a lock flag. While the flag is high, the watchdog-interrupt enable bit cannot change, whatever the write data holds.

A static strap input tells the block whether system-management mode is supported. If it is not, reset leaves the APM-command enable bit set. The firmware then sees system-management mode as already initialised and never enters it. Status bits are set by one-cycle event pulses and stay set until reset.

Top module: `smi_ctrl_regs`

## Requirements
- R1: A read with `req_rd_i` high returns the enable word at offset 0 and the status word at offset 4, both in the same cycle as the strobe.
- R2: `req_rdata_o` is zero for a read at any offset other than 0 or 4, and zero whenever `req_rd_i` is low.
- R3: A write at any offset other than 0 changes neither the enable word nor the status word.
- R4: A write at offset 0 loads every bit of the enable word that is set in the write mask from `req_wdata_i`, one clock edge after the strobe.
- R5: Enable bits that are clear in the write mask keep their old value through a write at offset 0.
- R6: While `wdt_lock_i` is high, the watchdog-interrupt enable (bit 13 by default, parameter `WDT_BIT`) keeps its value through any write.
- R7: After reset with `smm_avail_i` high, the enable word is zero, the status word is zero, and the write mask is all ones.
- R8: After reset with `smm_avail_i` low, the enable word holds only the APM-command enable bit (bit 5 by default, parameter `APM_BIT`), that is 0x0000_0020.
- R9: Each bit set in `ev_set_i` on a clock edge sets the matching status bit. Status bits stay set until reset.
- R10: `smi_en_o` and `smi_sts_o` always show the current enable and status words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smm_avail_i | input | 1 | Static strap: system-management mode is supported |
| wdt_lock_i | input | 1 | Lock from the timer-control block; freezes the watchdog-interrupt enable |
| ev_set_i | input | 32 | One-cycle event pulses that set status bits |
| req_wr_i | input | 1 | Write strobe |
| req_rd_i | input | 1 | Read strobe |
| req_addr_i | input | 3 | Byte offset within the 8-byte window |
| req_wdata_i | input | 32 | Write data, little-endian word |
| req_rdata_o | output | 32 | Read data, combinational |
| smi_en_o | output | 32 | Current enable word |
| smi_sts_o | output | 32 | Current status word |

## Verification
A wrong enable bit appears on `smi_en_o` on the clock edge that follows the faulty write, lock or reset. The bench compares that output with its reference model on every cycle, so such a fault is caught within one cycle. A status bit that is lost or set by mistake shows on `smi_sts_o` in the same way. A decode fault only shows during a read, so the bench reads every offset in the window. A fault in the write mask or the lock only shows when a write tries to flip a guarded bit. For that reason the writes use patterns that flip both guarded and free bits, and a second instance with a narrowed mask is checked alongside the first.

// File: rtl/smi_regs_pkg.sv
package smi_regs_pkg;
  localparam int unsigned SMI_DATA_W = 32;
  localparam int unsigned SMI_ADDR_W = 3;
  typedef logic [SMI_DATA_W-1:0] smi_word_t;
  typedef logic [SMI_ADDR_W-1:0] smi_addr_t;
  localparam smi_addr_t SMI_OFS_EN  = 3'd0;
  localparam smi_addr_t SMI_OFS_STS = 3'd4;
endpackage

// File: rtl/smi_reg_decode.sv
module smi_reg_decode
  import smi_regs_pkg::*;
(
  input  logic      wr_i,
  input  logic      rd_i,
  input  smi_addr_t addr_i,
  input  smi_word_t en_i,
  input  smi_word_t sts_i,
  output logic      en_wr_o,
  output smi_word_t rdata_o
);
  logic hit_en, hit_sts;

  assign hit_en  = (addr_i == SMI_OFS_EN);
  assign hit_sts = (addr_i == SMI_OFS_STS);
  assign en_wr_o = wr_i & hit_en;

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (hit_en)       rdata_o = en_i;
      else if (hit_sts) rdata_o = sts_i;
    end
  end
endmodule

// File: rtl/smi_en_reg.sv
module smi_en_reg
  import smi_regs_pkg::*;
#(
  parameter int unsigned WDT_BIT   = 13,
  parameter int unsigned APM_BIT   = 5,
  parameter smi_word_t   WMASK_RST = '1
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      smm_avail_i,
  input  logic      lock_i,
  input  logic      wr_i,
  input  smi_word_t wdata_i,
  output smi_word_t en_o
);
  localparam smi_word_t APM_ONE = smi_word_t'(1) << APM_BIT;

  smi_word_t en_q, en_d, wmask_q;

  // mask is loaded only at reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wmask_q <= WMASK_RST;
    else         wmask_q <= wmask_q;
  end

  for (genvar b = 0; b < SMI_DATA_W; b++) begin : g_bit
    if (b == WDT_BIT) begin : g_lockable
      assign en_d[b] = (wr_i && wmask_q[b] && !lock_i) ? wdata_i[b] : en_q[b];
    end else begin : g_plain
      assign en_d[b] = (wr_i && wmask_q[b]) ? wdata_i[b] : en_q[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= smm_avail_i ? '0 : APM_ONE;
    else         en_q <= en_d;
  end

  assign en_o = en_q;

  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(en_q[WDT_BIT]));  // R6
  AST_MASK_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((en_q ^ $past(en_q)) & ~wmask_q) == '0);  // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(en_q));  // R3
endmodule

// File: rtl/smi_sts_reg.sv
module smi_sts_reg
  import smi_regs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  smi_word_t ev_i,
  output smi_word_t sts_o
);
  smi_word_t sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= sts_q | ev_i;
  end

  assign sts_o = sts_q;

  AST_STS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (sts_q & $past(sts_q)) == $past(sts_q));  // R9
  AST_EV_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i != '0) |=> (sts_q & $past(ev_i)) == $past(ev_i));  // R9
endmodule

// File: rtl/smi_ctrl_regs.sv
module smi_ctrl_regs
  import smi_regs_pkg::*;
#(
  parameter int unsigned WDT_BIT   = 13,
  parameter int unsigned APM_BIT   = 5,
  parameter smi_word_t   WMASK_RST = '1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        smm_avail_i,
  input  logic        wdt_lock_i,
  input  logic [31:0] ev_set_i,
  input  logic        req_wr_i,
  input  logic        req_rd_i,
  input  logic [2:0]  req_addr_i,
  input  logic [31:0] req_wdata_i,
  output logic [31:0] req_rdata_o,
  output logic [31:0] smi_en_o,
  output logic [31:0] smi_sts_o
);
  smi_word_t en_w, sts_w;
  logic      en_wr;

  smi_reg_decode i_decode (
    .wr_i    (req_wr_i),
    .rd_i    (req_rd_i),
    .addr_i  (req_addr_i),
    .en_i    (en_w),
    .sts_i   (sts_w),
    .en_wr_o (en_wr),
    .rdata_o (req_rdata_o)
  );

  smi_en_reg #(
    .WDT_BIT   (WDT_BIT),
    .APM_BIT   (APM_BIT),
    .WMASK_RST (WMASK_RST)
  ) i_en_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .smm_avail_i (smm_avail_i),
    .lock_i      (wdt_lock_i),
    .wr_i        (en_wr),
    .wdata_i     (req_wdata_i),
    .en_o        (en_w)
  );

  smi_sts_reg i_sts_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (ev_set_i),
    .sts_o  (sts_w)
  );

  assign smi_en_o  = en_w;
  assign smi_sts_o = sts_w;

  AST_WR_OTHER_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_wr_i && req_addr_i != SMI_OFS_EN) |=> $stable(smi_en_o));  // R3
  AST_RD_HOLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_rd_i && req_addr_i != SMI_OFS_EN && req_addr_i != SMI_OFS_STS)
      |-> req_rdata_o == '0);  // R2
  AST_RD_EN_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_rd_i && req_addr_i == SMI_OFS_EN) |-> req_rdata_o == smi_en_o);  // R1
endmodule

// File: tb/test_smi_ctrl_regs.sv
module test_smi_ctrl_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MASK_B = 32'hFFFF_00FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smm = 1'b1, lock = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [31:0] ev = '0, wdata = '0;
  logic [2:0]  addr = '0;
  logic [31:0] rdata, en, sts, rdata_b, en_b, sts_b;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_en, exp_sts, exp_en_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  smi_ctrl_regs i_smi_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_n), .smm_avail_i(smm), .wdt_lock_i(lock),
    .ev_set_i(ev), .req_wr_i(wr), .req_rd_i(rd), .req_addr_i(addr),
    .req_wdata_i(wdata), .req_rdata_o(rdata), .smi_en_o(en), .smi_sts_o(sts));

  smi_ctrl_regs #(.WMASK_RST(MASK_B)) i_smi_ctrl_regs_b (
    .clk_i(clk), .rst_ni(rst_n), .smm_avail_i(smm), .wdt_lock_i(lock),
    .ev_set_i(ev), .req_wr_i(wr), .req_rd_i(rd), .req_addr_i(addr),
    .req_wdata_i(wdata), .req_rdata_o(rdata_b), .smi_en_o(en_b), .smi_sts_o(sts_b));

  function automatic logic [31:0] upd(logic [31:0] old, logic [31:0] d,
                                      logic [31:0] m, logic lk);
    logic [31:0] v = d;
    if (lk) v[13] = old[13];
    return (old & ~m) | (v & m);
  endfunction

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_en   = smm ? 32'h0 : 32'h20;
      exp_en_b = exp_en;
      exp_sts  = '0;
    end else begin
      if (wr && addr == 3'd0) begin
        exp_en   = upd(exp_en, wdata, 32'hFFFF_FFFF, lock);
        exp_en_b = upd(exp_en_b, wdata, MASK_B, lock);
      end
      exp_sts = exp_sts | ev;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk("R10 R4 en_o", en, exp_en);
    chk("R5 en_o mask", en_b, exp_en_b);
    chk("R9 sts_o", sts, exp_sts);
  end

  task automatic do_wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic do_rd(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk); rd = 1'b1; addr = a;
    #1 chk(tag, rdata, exp);
    rd = 1'b0;
  endtask

  task automatic do_rst(logic s);
    @(negedge clk); smm = s; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    do_rst(1'b1);
    chk("R7 en after reset", en, 32'h0);
    chk("R7 sts after reset", sts, 32'h0);
    do_rd(3'd0, 32'h0, "R1 read en reset");
    do_rd(3'd4, 32'h0, "R1 read sts reset");

    do_wr(3'd0, 32'hA5A5_1234);
    chk("R4 full mask write", en, 32'hA5A5_1234);
    chk("R5 narrowed mask write", en_b, 32'hA5A5_0034);
    do_rd(3'd0, 32'hA5A5_1234, "R1 read en");

    @(negedge clk); ev = 32'h0000_0101;
    @(negedge clk); ev = 32'h8000_0000;
    @(negedge clk); ev = 32'h0;
    chk("R9 sts capture", sts, 32'h8000_0101);
    repeat (3) @(negedge clk);
    chk("R9 sts sticky", sts, 32'h8000_0101);
    do_rd(3'd4, 32'h8000_0101, "R1 read sts");

    for (int a = 1; a < 8; a++) begin
      do_wr(3'(a), 32'hFFFF_FFFF);
      chk("R3 write other offset en", en, 32'hA5A5_1234);
      chk("R3 write other offset sts", sts, 32'h8000_0101);
    end
    for (int a = 1; a < 8; a++)
      if (a != 4) do_rd(3'(a), 32'h0, "R2 hole read zero");
    @(negedge clk); rd = 1'b0; addr = 3'd0;
    #1 chk("R2 idle rdata zero", rdata, 32'h0);

    @(negedge clk); lock = 1'b1;
    do_wr(3'd0, 32'hFFFF_FFFF);
    chk("R6 lock keeps bit13 clear", en, 32'hFFFF_DFFF);
    do_wr(3'd0, 32'h0);
    chk("R6 other bits still writable", en, 32'h0);
    @(negedge clk); lock = 1'b0;
    do_wr(3'd0, 32'h0000_2000);
    chk("R6 unlocked write bit13", en, 32'h0000_2000);
    @(negedge clk); lock = 1'b1;
    do_wr(3'd0, 32'h0);
    chk("R6 lock keeps bit13 set", en, 32'h0000_2000);
    @(negedge clk); lock = 1'b0;

    do_rst(1'b0);
    chk("R8 apm bit after reset", en, 32'h0000_0020);
    chk("R7 sts cleared", sts, 32'h0);
    do_rd(3'd0, 32'h0000_0020, "R8 read en");
    do_wr(3'd0, 32'h0);
    chk("R7 mask all ones after reset", en, 32'h0);

    do_rst(1'b1);
    chk("R7 second reset en", en, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule